// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel byte into an asynchronous serial frame on a single line. The frame layout comes from an 8-bit control byte: the number of data bits, whether a parity bit is sent and how it is formed, how long the stop period is, and whether the line is forced low to signal a break. The bit rate comes from a strobe at sixteen times the bit rate, and each frame bit lasts sixteen of those strobes.

A one-byte holding register sits in front of the shift register. Software, or a bus front end, can queue the next byte while the current one is still on the wire. That byte then follows with no idle gap. Two flags report whether the holding register and the shifter are empty. The frame format is captured when a byte moves into the shifter, so the control byte may be changed while a frame is in flight without corrupting it.

Top module: `lcr_serial_tx`

## Requirements
- R1: After a synchronous reset, `txd` is 1, and `hold_empty` and `shift_empty` are both 1.
- R2: A frame opens with a start bit at 0, followed by the data bits with the least significant bit first. Each start, data and parity bit lasts exactly 16 consumed `baud_tick` pulses. The idle line is 1.
- R3: `line_ctrl[1:0]` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of `load_data` are not sent.
- R4: `line_ctrl[3]` = 0 sends no parity bit. With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 0, the parity bit follows the data bits. `line_ctrl[4]` = 1 selects even parity (the bit equals the XOR of the sent data bits). `line_ctrl[4]` = 0 selects odd parity (the bit is the inverse of that XOR).
- R5: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 1, the parity bit is the constant 1 when `line_ctrl[4]` = 0 and the constant 0 when `line_ctrl[4]` = 1. With `line_ctrl[3]` = 0, `line_ctrl[5]` has no effect.
- R6: The stop period is at 1 and lasts 16 ticks when `line_ctrl[2]` = 0. When `line_ctrl[2]` = 1 it lasts 32 ticks, or 24 ticks when the word length is 5.
- R7: While `line_ctrl[6]` = 1, `txd` is 0 whatever the shifter is doing. Frame timing continues underneath, and normal output returns as soon as the bit is cleared.
- R8: A byte loaded while both flags are 1 sets `hold_empty` to 0 for one cycle. On the next clock the byte enters the shifter: the start bit appears, `hold_empty` returns to 1 and `shift_empty` falls to 0.
- R9: A byte loaded while a frame is in progress waits in the holding register with `hold_empty` at 0. It moves into the shifter on the tick that ends the current stop period, so its start bit follows with no idle time, and `hold_empty` rises at that transfer.
- R10: `shift_empty` is 0 from the transfer until the tick that ends the last stop period with nothing waiting, at which point it returns to 1.
- R11: A second load while a byte is already waiting replaces the waiting byte. Only the later byte is sent.
- R12: The format fields `line_ctrl[5:0]` are captured at the transfer into the shifter. Changes made during a frame do not alter that frame's length or content. `line_ctrl[7]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| load | input | 1 | Write strobe for `load_data` into the holding register |
| load_data | input | 8 | Byte to transmit |
| line_ctrl | input | 8 | Frame format and break control |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register has no waiting byte |
| shift_empty | output | 1 | Shifter is idle |

## Verification
Most internal faults show up as a wrong bit value at the sampling midpoint of some frame bit, because a corrupted shift register, bit index or latched parity value is visible within 16 ticks. Faults in the tick counter or in the stop-length decode change where frames end. They are caught at the end of the same frame: the start bit of a queued byte does not come exactly one stop period later, or `shift_empty` does not rise on that tick. Faults in the holding path, such as a lost transfer, a missed overwrite or a stale flag, show within one or two clocks of a load, or as a missing or unexpected frame.

// File: rtl/sertx_pkg.sv
// Shared constants and types for the line-control serial transmitter.
// Assumes at most 8 data bits and a fixed 16x oversampling factor.
package sertx_pkg;
    localparam int MAX_BITS  = 8;
    localparam int OSR       = 16;
    localparam int BITCNT_W  = $clog2(MAX_BITS + 1);
    localparam int TICK_W    = $clog2(2 * OSR + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Frame shape fields that the shifter captures at transfer.
    typedef struct packed {
        logic [BITCNT_W-1:0] data_bits;
        logic                parity_on;
        logic [TICK_W-1:0]   stop_ticks;
    } frame_fmt_t;
endpackage

// File: rtl/sertx_fmt_decode.sv
// Decodes the control byte into frame length fields and parity selects.
// Purely combinational; assumes a minimum word length of 5 bits.
module sertx_fmt_decode
    import sertx_pkg::*;
(
    input  logic [5:0]  ctrl_i,
    output frame_fmt_t  fmt_o,
    output logic        parity_odd_o,
    output logic        parity_stick_o
);
    localparam logic [BITCNT_W-1:0] MIN_BITS = BITCNT_W'(5);
    localparam logic [TICK_W-1:0]   STOP_ONE = TICK_W'(OSR);
    localparam logic [TICK_W-1:0]   STOP_MID = TICK_W'(OSR + OSR / 2);
    localparam logic [TICK_W-1:0]   STOP_TWO = TICK_W'(2 * OSR);

    // Map the word, parity and stop selects to lengths and flags.
    always_comb begin
        fmt_o.data_bits = MIN_BITS + {{(BITCNT_W-2){1'b0}}, ctrl_i[1:0]};
        fmt_o.parity_on = ctrl_i[3];
        if (!ctrl_i[2])
            fmt_o.stop_ticks = STOP_ONE;
        else if (ctrl_i[1:0] == 2'b00)
            fmt_o.stop_ticks = STOP_MID;
        else
            fmt_o.stop_ticks = STOP_TWO;
        parity_odd_o   = !ctrl_i[4];
        parity_stick_o = ctrl_i[5];
    end
endmodule

// File: rtl/sertx_parity_gen.sv
// Computes the parity bit for a word of the selected length.
// Bits above the word length are masked; stick mode forces a constant.
module sertx_parity_gen
    import sertx_pkg::*;
#(
    parameter int DATA_W = MAX_BITS
) (
    input  logic [DATA_W-1:0]   data_i,
    input  logic [BITCNT_W-1:0] nbits_i,
    input  logic                odd_i,
    input  logic                stick_i,
    output logic                par_o
);
    logic [DATA_W-1:0] masked;

    // Keep only the bits that will actually be sent.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data_i[i] & (BITCNT_W'(i) < nbits_i);
    end

    // Select normal even/odd parity or the stick constant.
    always_comb begin
        if (stick_i)
            par_o = odd_i;
        else if (odd_i)
            par_o = ~(^masked);
        else
            par_o = ^masked;
    end
endmodule

// File: rtl/sertx_hold.sv
// One-byte holding register in front of the shifter.
// A load always wins: it overwrites any waiting byte, and a load in the
// same cycle as a transfer keeps the register full with the new byte.
module sertx_hold
    import sertx_pkg::*;
#(
    parameter int DATA_W = MAX_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              xfer_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // Track occupancy and capture written bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (load_i)
                data_q <= load_data_i;
            if (load_i)
                full_q <= 1'b1;
            else if (xfer_i)
                full_q <= 1'b0;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

    a_r9_empty_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !load_i) |=> !full_q);

    a_r11_last_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (full_q && data_q == $past(load_data_i)));
endmodule

// File: rtl/sertx_shifter.sv
// Frame sequencer and shift register. It takes a byte from the holding
// register when idle, or on the tick that ends a stop period. The frame
// format and parity bit are captured at that moment. Bits advance only on
// baud ticks, OSR ticks per bit.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_W = MAX_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  frame_fmt_t        fmt_i,
    input  logic              par_i,
    output logic              xfer_o,
    output logic              line_o,
    output logic              idle_o
);
    localparam logic [TICK_W-1:0] BIT_LAST = TICK_W'(OSR - 1);

    tx_state_e           state;
    logic [TICK_W-1:0]   cnt;
    logic [BITCNT_W-1:0] bit_idx;
    logic [DATA_W-1:0]   shreg;
    frame_fmt_t          fmt_q;
    logic                par_q;
    logic                bit_end;
    logic                stop_end;

    // Detect bit and stop-period boundaries and the transfer request.
    always_comb begin
        bit_end  = tick_i && (cnt == BIT_LAST);
        stop_end = tick_i && (cnt == fmt_q.stop_ticks - TICK_W'(1));
        xfer_o   = hold_full_i &&
                   ((state == ST_IDLE) || (state == ST_STOP && stop_end));
    end

    // Step the frame state, tick counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            fmt_q   <= '0;
            par_q   <= 1'b0;
        end else if (xfer_o) begin
            state   <= ST_START;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= hold_data_i;
            fmt_q   <= fmt_i;
            par_q   <= par_i;
        end else if (state != ST_IDLE && tick_i) begin
            if (state == ST_STOP) begin
                if (stop_end) begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + TICK_W'(1);
                end
            end else if (bit_end) begin
                cnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == fmt_q.data_bits - BITCNT_W'(1))
                            state <= fmt_q.parity_on ? ST_PARITY : ST_STOP;
                        else
                            bit_idx <= bit_idx + BITCNT_W'(1);
                    end
                    ST_PARITY: state <= ST_STOP;
                    default:   state <= ST_IDLE;
                endcase
            end else begin
                cnt <= cnt + TICK_W'(1);
            end
        end
    end

    // Choose the line level for the current frame element.
    always_comb begin
        case (state)
            ST_START:  line_o = 1'b0;
            ST_DATA:   line_o = shreg[0];
            ST_PARITY: line_o = par_q;
            default:   line_o = 1'b1;
        endcase
    end

    assign idle_o = (state == ST_IDLE);

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !tick_i) |=> (state == $past(state)));

    a_r3_index_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bit_idx < fmt_q.data_bits));

    a_r6_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && $past(state) != ST_STOP) |->
            ($past(state) == ST_DATA || $past(state) == ST_PARITY));
endmodule

// File: rtl/lcr_serial_tx.sv
// Top of the configurable serial transmitter. It decodes the control byte,
// forms parity from the waiting byte, and feeds the holding register into
// the shifter. Break overrides the line level. Assumes baud_tick is a
// one-cycle pulse at 16x the bit rate.
module lcr_serial_tx
    import sertx_pkg::*;
#(
    parameter int DATA_W = MAX_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [7:0]        line_ctrl,
    output logic              txd,
    output logic              shift_empty,
    output logic              hold_empty
);
    frame_fmt_t        fmt;
    logic              par_odd;
    logic              par_stick;
    logic              par_bit;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              xfer;
    logic              line_bit;
    logic              shifter_idle;
    logic              unused_ctrl;

    assign unused_ctrl = line_ctrl[7];

    sertx_fmt_decode u_decode (
        .ctrl_i         (line_ctrl[5:0]),
        .fmt_o          (fmt),
        .parity_odd_o   (par_odd),
        .parity_stick_o (par_stick)
    );

    sertx_parity_gen #(.DATA_W(DATA_W)) u_parity (
        .data_i  (hold_data),
        .nbits_i (fmt.data_bits),
        .odd_i   (par_odd),
        .stick_i (par_stick),
        .par_o   (par_bit)
    );

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_data_i (load_data),
        .xfer_i      (xfer),
        .full_o      (hold_full),
        .data_o      (hold_data)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (baud_tick),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .fmt_i       (fmt),
        .par_i       (par_bit),
        .xfer_o      (xfer),
        .line_o      (line_bit),
        .idle_o      (shifter_idle)
    );

    // Drive the line, with break forcing it low.
    always_comb begin
        txd         = line_ctrl[6] ? 1'b0 : line_bit;
        hold_empty  = !hold_full;
        shift_empty = shifter_idle;
    end

    a_r10_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && !line_ctrl[6]) |-> txd);
endmodule

// File: tb/lcr_serial_tx_test.sv
`timescale 1ns/1ps
module lcr_serial_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic [7:0] line_ctrl = 8'h03;
    logic       txd, shift_empty, hold_empty;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] q_data[$];
    logic [7:0] q_lcr[$];

    lcr_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load),
        .load_data(load_data), .line_ctrl(line_ctrl), .txd(txd),
        .shift_empty(shift_empty), .hold_empty(hold_empty)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nbits(input logic [7:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic int frame_ticks(input logic [7:0] c);
        int st;
        st = !c[2] ? 16 : (c[1:0] == 2'b00 ? 24 : 32);
        return 16 * (1 + nbits(c) + int'(c[3])) + st;
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic [7:0] c);
        logic x;
        x = 1'b0;
        for (int i = 0; i < nbits(c); i++) x ^= d[i];
        if (c[5]) return !c[4];
        return c[4] ? x : !x;
    endfunction

    // Monitor: generates the tick, decodes frames and checks timing.
    int   tdiv = 0;
    bit   busy = 0;
    bit   brk_in = 0;
    bit   ld_prev = 0;
    int   rel = 0;
    always @(negedge clk) begin
        bit consumed;
        consumed = baud_tick;
        baud_tick <= (tdiv == 3);
        tdiv = (tdiv + 1) % 4;
        if (rst_n) begin
            if (line_ctrl[6]) begin
                chk(txd == 1'b0, "R7 break", txd, 0);
                if (busy) brk_in = 1;
            end
            if (!busy) begin
                if (txd == 1'b0 && !line_ctrl[6]) begin
                    chk(q_data.size() > 0, "R2 unexpected start", q_data.size(), 1);
                    busy = 1; rel = 0; brk_in = 0;
                end
            end else if (consumed) begin
                rel++;
                if (rel == frame_ticks(q_lcr[0])) begin
                    void'(q_data.pop_front());
                    void'(q_lcr.pop_front());
                    if (q_data.size() > 0 && !ld_prev) begin
                        chk(txd == 1'b0 || line_ctrl[6], "R9 back-to-back start", txd, 0);
                        chk(hold_empty == 1'b1, "R9 hold empty at transfer", hold_empty, 1);
                        rel = 0; brk_in = line_ctrl[6];
                    end else begin
                        busy = 0;
                        chk(shift_empty == 1'b1, "R10 shifter empty at end", shift_empty, 1);
                        if (!line_ctrl[6]) chk(txd == 1'b1, "R6 line idle after stop", txd, 1);
                    end
                end else if (rel % 16 == 8 && !brk_in && !line_ctrl[6]) begin
                    int k;
                    logic e;
                    string r;
                    k = rel / 16;
                    if (k == 0) begin e = 1'b0; r = "R2 start bit"; end
                    else if (k <= nbits(q_lcr[0])) begin e = q_data[0][k-1]; r = "R3 data bit"; end
                    else if (k == nbits(q_lcr[0]) + 1 && q_lcr[0][3]) begin
                        e = par_of(q_data[0], q_lcr[0]);
                        r = q_lcr[0][5] ? "R5 stick parity" : "R4 parity";
                    end else begin e = 1'b1; r = "R6 stop bit"; end
                    chk(txd == e, r, txd, e);
                    if (k == 0) chk(shift_empty == 1'b0, "R10 busy flag", shift_empty, 0);
                end
            end
        end
        ld_prev = load;
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_lcr(input logic [7:0] c);
        @(posedge clk); #1 line_ctrl = c;
    endtask

    task automatic send(input logic [7:0] d);
        while (!hold_empty) @(negedge clk);
        @(posedge clk); #1;
        load = 1'b1; load_data = d;
        q_data.push_back(d); q_lcr.push_back(line_ctrl);
        @(posedge clk); #1 load = 1'b0;
    endtask

    task automatic wait_idle();
        while (q_data.size() > 0 || !shift_empty || !hold_empty) @(negedge clk);
        cyc(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F3A));
        cyc(4);
        @(negedge clk);
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(hold_empty == 1'b1, "R1 reset hold_empty", hold_empty, 1);
        chk(shift_empty == 1'b1, "R1 reset shift_empty", shift_empty, 1);
        @(posedge clk); #1 rst_n = 1'b1;
        cyc(5);

        // R8: load from idle, flags over the next two clocks.
        set_lcr(8'h03);
        @(posedge clk); #1;
        load = 1'b1; load_data = 8'hA5;
        q_data.push_back(8'hA5); q_lcr.push_back(8'h03);
        @(negedge clk);
        @(posedge clk); #1 load = 1'b0;
        @(negedge clk);
        chk(hold_empty == 1'b0, "R8 hold flag after load", hold_empty, 0);
        chk(txd == 1'b1, "R8 line before transfer", txd, 1);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R8 hold flag after transfer", hold_empty, 1);
        chk(shift_empty == 1'b0, "R8 shifter busy", shift_empty, 0);
        chk(txd == 1'b0, "R8 start bit", txd, 0);
        wait_idle();

        // R9: back-to-back bytes; R11: overwrite of a waiting byte.
        send(8'h3C);
        cyc(10);
        send(8'h11);
        cyc(2);
        @(negedge clk);
        chk(hold_empty == 1'b0, "R9 byte waiting", hold_empty, 0);
        @(posedge clk); #1;
        load = 1'b1; load_data = 8'hE7;
        q_data[q_data.size()-1] = 8'hE7;
        @(posedge clk); #1 load = 1'b0;
        wait_idle();

        // R5: stick parity, both polarities; R6: 1.5 and 2 stop bits.
        set_lcr(8'h2B); send(8'h0F); send(8'h01);
        wait_idle();
        set_lcr(8'h3B); send(8'h0F); send(8'h7E);
        wait_idle();
        set_lcr(8'h04); send(8'h15); send(8'h0A);
        wait_idle();
        set_lcr(8'h87); send(8'hC3); send(8'h5A);
        wait_idle();

        // R7: break while idle and during a frame.
        set_lcr(8'h43); cyc(20);
        @(negedge clk);
        chk(txd == 1'b0, "R7 break while idle", txd, 0);
        set_lcr(8'h03); cyc(2);
        @(negedge clk);
        chk(txd == 1'b1, "R7 line after break", txd, 1);
        send(8'h99); cyc(100);
        set_lcr(8'h43); cyc(40);
        set_lcr(8'h03);
        send(8'h66);
        wait_idle();

        // R12: format changed mid-frame does not alter the frame.
        begin
            int n;
            set_lcr(8'h03);
            send(8'h81);
            cyc(40);
            set_lcr(8'h0C);
            n = 41;
            while (!shift_empty) begin @(posedge clk); n++; end
            chk(n <= frame_ticks(8'h03) * 4 + 2 && n >= frame_ticks(8'h03) * 4 - 4,
                "R12 frame length kept", n, frame_ticks(8'h03) * 4);
            wait_idle();
        end

        // Random formats and data, sometimes back-to-back.
        for (int f = 0; f < 40; f++) begin
            logic [7:0] c;
            c = 8'($urandom()) & 8'hBF;
            set_lcr(c);
            send(8'($urandom()));
            if ($urandom() % 2 == 0) send(8'($urandom()));
            wait_idle();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule